// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a CRT or LCD display. A host loads the timing fields through a small byte-wide register port. Two counters, one for pixels along a line and one for lines within a frame, walk the raster. From them the block derives a display-enable window, horizontal and vertical sync pulses with programmable polarity, and the current pixel and line coordinates.

Horizontal quantities are coded in 8-pixel units as 8×(field+1). Vertical quantities are coded in lines as field+1. A sync pulse starts at a programmable distance past the end of the active area. If the pulse would run past the end of the non-display period, it is cut off at that point. Host writes go to a live register bank. That bank is copied into a working copy only when a frame wraps, so a write made during a frame never changes the frame in progress. A read-only status bit reports whether the vertical non-display period is in progress.

Top module: `dtg_top`

## Requirements
- R1: Each line lasts HA+HB pixel clocks, where HA = 8×(reg0[6:0]+1) and HB = 8×(reg1[4:0]+1). `pix_x` counts 0 to HA+HB-1 and then wraps to 0.
- R2: Each frame has VA+VB lines, where VA = reg5[1:0]:reg4[7:0] + 1 and VB = reg6[5:0]+1. `line_y` steps by one when `pix_x` wraps, and returns to 0 after line VA+VB-1.
- R3: `de` is 1 exactly when `pix_x` < HA and `line_y` < VA.
- R4: The horizontal sync is asserted while HA+8×(reg2[4:0]+1) ≤ `pix_x` < that position + 8×(reg3[3:0]+1). The pulse is cut off at the end of the line.
- R5: The vertical sync is asserted for every pixel of the lines where VA+(reg7[5:0]+1) ≤ `line_y` < that position + (reg8[2:0]+1). The pulse is cut off at the end of the frame.
- R6: reg3 bit 7 sets the horizontal sync polarity and reg8 bit 7 sets the vertical sync polarity. A value of 1 drives the sync pin high while asserted. A value of 0 drives it low while asserted and high when idle.
- R7: Bit 7 of reg6 reads 1 while `line_y` ≥ VA and 0 otherwise. Writes to that bit are ignored.
- R8: Register bits without a field read 0, and writes to them are ignored. Addresses 9 to 15 read 0.
- R9: Register writes take effect from the first pixel of the next frame. The frame in progress keeps its timing.
- R10: After reset, both counters are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Display enable (active area) |
| pix_x | output | 11 | Current pixel within the line |
| line_y | output | 11 | Current line within the frame |

## Verification
The assertions assume that the host never changes the register bank in a way that makes the counters run past a frame boundary. This holds because the working copy is swapped only while both counters wrap. They also assume that a sync start always lies past the active area, which the field encoding guarantees. The stimulus loads one configuration right after reset. It then writes a second configuration in the middle of a frame, so every change lands on a frame boundary. Both configurations are swept pixel by pixel over a whole frame, and each output is compared against values computed arithmetically from the field values.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int HACT_W = 7;
  localparam int HBLK_W = 5;
  localparam int HSS_W  = 5;
  localparam int HSW_W  = 4;
  localparam int VACT_W = 10;
  localparam int VBLK_W = 6;
  localparam int VSS_W  = 6;
  localparam int VSW_W  = 3;
  localparam int H_SH   = 3;
  localparam int V_SH   = 0;
  localparam int CNT_W  = 11;
  localparam int POL_B  = 7;

  localparam logic [ADDR_W-1:0] A_HACT = 4'd0;
  localparam logic [ADDR_W-1:0] A_HBLK = 4'd1;
  localparam logic [ADDR_W-1:0] A_HSS  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HSW  = 4'd3;
  localparam logic [ADDR_W-1:0] A_VALO = 4'd4;
  localparam logic [ADDR_W-1:0] A_VAHI = 4'd5;
  localparam logic [ADDR_W-1:0] A_VBLK = 4'd6;
  localparam logic [ADDR_W-1:0] A_VSS  = 4'd7;
  localparam logic [ADDR_W-1:0] A_VSW  = 4'd8;

  typedef struct packed {
    logic [HACT_W-1:0] hact;
    logic [HBLK_W-1:0] hblk;
    logic [HSS_W-1:0]  hss;
    logic [HSW_W-1:0]  hsw;
    logic              hpol;
    logic [VACT_W-1:0] vact;
    logic [VBLK_W-1:0] vblk;
    logic [VSS_W-1:0]  vss;
    logic [VSW_W-1:0]  vsw;
    logic              vpol;
  } cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_end,
  input  logic              vnd,
  output cfg_t              cfg_s,
  output logic [DATA_W-1:0] rdata
);
  cfg_t live_q, live_d;
  cfg_t shad_q, shad_d;

  always_comb begin
    live_d = live_q;
    if (we) begin
      case (addr)
        A_HACT: live_d.hact = wdata[HACT_W-1:0];
        A_HBLK: live_d.hblk = wdata[HBLK_W-1:0];
        A_HSS:  live_d.hss  = wdata[HSS_W-1:0];
        A_HSW: begin
          live_d.hsw  = wdata[HSW_W-1:0];
          live_d.hpol = wdata[POL_B];
        end
        A_VALO: live_d.vact[DATA_W-1:0] = wdata;
        A_VAHI: live_d.vact[VACT_W-1:DATA_W] = wdata[VACT_W-DATA_W-1:0];
        A_VBLK: live_d.vblk = wdata[VBLK_W-1:0];
        A_VSS:  live_d.vss  = wdata[VSS_W-1:0];
        A_VSW: begin
          live_d.vsw  = wdata[VSW_W-1:0];
          live_d.vpol = wdata[POL_B];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    shad_d = shad_q;
    if (frame_end) shad_d = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      shad_q <= '0;
    end else begin
      live_q <= live_d;
      shad_q <= shad_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_HACT: rdata = DATA_W'(live_q.hact);
      A_HBLK: rdata = DATA_W'(live_q.hblk);
      A_HSS:  rdata = DATA_W'(live_q.hss);
      A_HSW: begin
        rdata = DATA_W'(live_q.hsw);
        rdata[POL_B] = live_q.hpol;
      end
      A_VALO: rdata = live_q.vact[DATA_W-1:0];
      A_VAHI: rdata = DATA_W'(live_q.vact[VACT_W-1:DATA_W]);
      A_VBLK: begin
        rdata = DATA_W'(live_q.vblk);
        rdata[POL_B] = vnd;
      end
      A_VSS:  rdata = DATA_W'(live_q.vss);
      A_VSW: begin
        rdata = DATA_W'(live_q.vsw);
        rdata[POL_B] = live_q.vpol;
      end
      default: rdata = '0;
    endcase
  end

  assign cfg_s = shad_q;
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int ACT_W = 7,
  parameter int BLK_W = 5,
  parameter int SS_W  = 5,
  parameter int SW_W  = 4,
  parameter int SH    = 3,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [ACT_W-1:0] act_f,
  input  logic [BLK_W-1:0] blk_f,
  input  logic [SS_W-1:0]  ss_f,
  input  logic [SW_W-1:0]  sw_f,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             sync_on,
  output logic             last
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] act_len, tot_len, ss_pos, se_pos;

  always_comb begin
    act_len = (SUM_W'(act_f) + SUM_W'(1)) << SH;
    tot_len = act_len + ((SUM_W'(blk_f) + SUM_W'(1)) << SH);
    ss_pos  = act_len + ((SUM_W'(ss_f) + SUM_W'(1)) << SH);
    se_pos  = ss_pos + ((SUM_W'(sw_f) + SUM_W'(1)) << SH);
  end

  assign last    = (SUM_W'(cnt_q) == tot_len - SUM_W'(1));
  assign active  = (SUM_W'(cnt_q) < act_len);
  assign sync_on = (SUM_W'(cnt_q) >= ss_pos) && (SUM_W'(cnt_q) < se_pos);

  always_comb begin
    cnt_d = cnt_q;
    if (adv) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CNT_W-1:0]  pix_x,
  output logic [CNT_W-1:0]  line_y
);
  cfg_t cfg_s;
  logic h_act, h_on, h_last;
  logic v_act, v_on, v_last;
  logic frame_end, vnd;

  assign frame_end = h_last & v_last;
  assign vnd       = ~v_act;

  dtg_regs regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .frame_end(frame_end), .vnd(vnd), .cfg_s(cfg_s), .rdata(reg_rdata)
  );

  dtg_axis #(
    .ACT_W(HACT_W), .BLK_W(HBLK_W), .SS_W(HSS_W), .SW_W(HSW_W),
    .SH(H_SH), .CNT_W(CNT_W)
  ) hax_i (
    .clk(clk), .rst_n(rst_n), .adv(1'b1),
    .act_f(cfg_s.hact), .blk_f(cfg_s.hblk), .ss_f(cfg_s.hss), .sw_f(cfg_s.hsw),
    .cnt(pix_x), .active(h_act), .sync_on(h_on), .last(h_last)
  );

  dtg_axis #(
    .ACT_W(VACT_W), .BLK_W(VBLK_W), .SS_W(VSS_W), .SW_W(VSW_W),
    .SH(V_SH), .CNT_W(CNT_W)
  ) vax_i (
    .clk(clk), .rst_n(rst_n), .adv(h_last),
    .act_f(cfg_s.vact), .blk_f(cfg_s.vblk), .ss_f(cfg_s.vss), .sw_f(cfg_s.vsw),
    .cnt(line_y), .active(v_act), .sync_on(v_on), .last(v_last)
  );

  assign de    = h_act & v_act;
  assign hsync = cfg_s.hpol ? h_on : ~h_on;
  assign vsync = cfg_s.vpol ? v_on : ~v_on;
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
  import dtg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  pix_x,
  input logic [CNT_W-1:0]  line_y,
  input logic              de,
  input logic              hsync,
  input logic              hpol,
  input logic              vnd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  p_xstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pix_x == $past(pix_x) + CNT_W'(1)) || (pix_x == '0)));

  p_ystep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> $stable(line_y));

  p_hidle_de_r4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == !hpol));

  p_de_vnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !vnd);

  p_vnd_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vnd) |-> (pix_x == '0));

  p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > A_VSW) |-> (reg_rdata == '0));
endmodule

bind dtg_top dtg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y), .de(de),
  .hsync(hsync), .hpol(cfg_s.hpol), .vnd(vnd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/dtg_top_tb_top.sv
`timescale 1ns/1ps
module dtg_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic hsync, vsync, de;
  logic [10:0] pix_x, line_y;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dtg_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_x(pix_x), .line_y(line_y)
  );

  int wa[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 8};
  int wd_a[9] = '{3, 2, 0, 8'h01, 4, 0, 3, 1, 8'h00};
  int wd_b[9] = '{1, 3, 2, 8'h83, 1, 1, 8'h85, 4, 8'h82};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1;
    reg_addr = 4'(a);
    reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    reg_addr = 4'(a);
    #1;
    chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
  endtask

  task automatic scan_frame(input int cw[9], input bit do_wr);
    int ha, hb, va, vb, hs0, hs1, vs0, vs1, hw, vw, H, V;
    bit hp, vp;
    ha = 8 * (cw[0] + 1);
    hb = 8 * (cw[1] + 1);
    hs0 = ha + 8 * (cw[2] + 1);
    hs1 = hs0 + 8 * ((cw[3] & 15) + 1);
    hp = cw[3][7];
    va = (((cw[5] & 3) << 8) | cw[4]) + 1;
    vb = (cw[6] & 63) + 1;
    vs0 = va + (cw[7] & 63) + 1;
    vw = (cw[8] & 7) + 1;
    vs1 = vs0 + vw;
    vp = cw[8][7];
    hw = hs1 - hs0;
    H = ha + hb;
    V = va + vb;
    for (int n = 0; n < H * V; n++) begin
      int x, y;
      bit hon, von;
      x = n % H;
      y = n / H;
      hon = (x >= hs0) && (x < hs1);
      von = (y >= vs0) && (y < vs1);
      chk(pix_x == 11'(x), "R1 pix_x", pix_x, x);
      chk(line_y == 11'(y), "R2 line_y", line_y, y);
      chk(de == ((x < ha) && (y < va)), "R3 de", de, (x < ha) && (y < va));
      chk(hsync == (hp ? hon : !hon), "R4/R6 hsync", hsync, hp ? hon : !hon);
      chk(vsync == (vp ? von : !von), "R5/R6 vsync", vsync, vp ? von : !von);
      if (!reg_we)
        chk(reg_rdata[7] == (y >= va), "R7 status", reg_rdata[7], y >= va);
      if (do_wr && n >= 100 && n < 109) begin
        reg_we = 1'b1;
        reg_addr = 4'(wa[n - 100]);
        reg_wdata = 8'(wd_b[n - 100]);
      end else begin
        reg_we = 1'b0;
        reg_addr = 4'd6;
      end
      @(negedge clk);
    end
    if (hw < 0) $display("unexpected sync width");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int f0;
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(pix_x == 0, "R10 reset pix_x", pix_x, 0);
    chk(line_y == 0, "R10 reset line_y", line_y, 0);
    for (int a = 0; a < 9; a++) rd_chk(a, 0, "R10 reset readback");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) wr(wa[i], wd_a[i]);
    rd_chk(6, 3, "R7 status low in active area");
    while (!(pix_x == 0 && line_y == 0)) @(negedge clk);
    reg_addr = 4'd6;
    f0 = fails;
    scan_frame(wd_a, 1'b1);
    chk(fails == f0, "R9 frame kept timing across mid-frame write", fails - f0, 0);
    scan_frame(wd_b, 1'b0);
    wr(1, 8'hFF);
    rd_chk(1, 8'h1F, "R8 masked hblank");
    wr(0, 8'hFF);
    rd_chk(0, 8'h7F, "R8 masked hactive");
    wr(5, 8'hFF);
    rd_chk(5, 8'h03, "R8 masked vactive high");
    wr(3, 8'h7F);
    rd_chk(3, 8'h0F, "R8 masked hsync width");
    wr(12, 8'hAB);
    rd_chk(12, 0, "R8 unused address");
    rd_chk(15, 0, "R8 unused address");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule